// File: doc/BRIEF.md
# DMA Request and Bus-Mode Sequencer

This block is the control sequencer of a single DMA channel. It decides when a transfer may begin, how long the channel keeps the bus, and when each transfer unit is issued to a datapath. A request comes from one of two places. It can come from an internal automatic source, which is always pending while the channel is armed. It can also come from an active-low external request pin, which is sensed either by its low level or by its falling edge.

Once a request is accepted, the sequencer raises a bus request. While the bus grant is high, it emits one transfer strobe per cycle. There are three bus modes. In cycle-steal mode the bus is released after every unit. In burst mode the bus is held until the whole count is done. In block mode a block-size run of transfers follows each external request. An optional acknowledge pulse tells the requesting device that its request has been taken, so it knows when to withdraw the request.

Arming loads a transfer count and enables the channel. When the count is used up, the channel disables itself and pulses a done flag. An abort input disables the channel at any point. Address generation, the datapath and the bus arbiter lie outside this block.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, bus_req, xfer_stb, ack, active and done are all 0.
- R2: With src_ext=0 (automatic request), arming with a nonzero count sets active on the next cycle, and bus_req rises one cycle later without any external input.
- R3: xfer_stb is high exactly in cycles where bus_req and bus_gnt are both high. The number of strobes equals the armed count. In the cycle after the last strobe, done is high for one cycle and active is 0.
- R4: Cycle-steal mode applies for mode_sel=0, and for the illegal combinations: mode_sel=2 with src_ext=0, mode_sel=1 with src_ext=1, and mode_sel=3. In this mode, bus_req is 0 in the cycle after every strobe.
- R5: Burst mode (src_ext=0, mode_sel=1) keeps bus_req high from acquisition until the count is exhausted, including across cycles without grant.
- R6: With src_ext=1 and sense_edge=0, a request is accepted only while req_n is 0. No strobe occurs while req_n stays 1.
- R7: With src_ext=1 and sense_edge=1, one request is accepted per falling edge of req_n (1 then 0 on consecutive samples). Holding req_n at 0 does not retrigger. An edge seen while the channel is armed but busy is remembered for later.
- R8: Block mode (src_ext=1, mode_sel=2) issues blk_size strobes per accepted request with bus_req held, or fewer if the count runs out first. A blk_size of 0 acts as 1.
- R9: With src_ext=1 and ack_en=1, ack pulses together with the first strobe of each accepted request, so once per whole block in block mode. ack is never high when ack_en=0 or src_ext=0.
- R10: An abort pulse makes active and bus_req 0 on the next cycle, with no done pulse.
- R11: An arm pulse while active has no effect on the count. Arming with a count of 0 leaves active at 0 and pulses done on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Pulse: enable the channel and load xfer_count |
| abort | input | 1 | Pulse: disable the channel immediately |
| xfer_count | input | CNT_W | Total transfer units, sampled on arm |
| src_ext | input | 1 | 0 automatic request, 1 external request pin |
| mode_sel | input | 2 | 0 cycle-steal, 1 burst, 2 block, 3 treated as cycle-steal |
| sense_edge | input | 1 | External sensing: 0 low level, 1 falling edge |
| ack_en | input | 1 | Enable the acceptance acknowledge pulse |
| blk_size | input | BLK_W | Transfers per external request in block mode |
| req_n | input | 1 | Active-low external request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request / hold |
| xfer_stb | output | 1 | One transfer unit issued this cycle |
| ack | output | 1 | Request acceptance acknowledge |
| active | output | 1 | Channel enabled |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The hardest case to reach from the ports is an external falling edge that arrives while a block is still being transferred. That edge has to be remembered and served as a fresh block with its own single acknowledge. The same edge must not be merged into the running block or lost. To get there, the stimulus spaces request edges closely against a randomly stuttering grant, so edges land in the waiting, holding and granted phases. A cycle-accurate reference model follows each of these cases and compares every output on every clock. Further scenarios hold the request low under edge sensing, use each illegal mode pairing, and re-arm while the channel is busy.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        BM_STEAL = 2'd0,
        BM_BURST = 2'd1,
        BM_BLOCK = 2'd2
    } eff_mode_e;

    localparam logic [1:0] MODE_BURST = 2'd1;
    localparam logic [1:0] MODE_BLOCK = 2'd2;

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
    import dma_seq_pkg::*;
(
    input  logic       src_ext,
    input  logic [1:0] mode_sel,
    output eff_mode_e  eff_mode
);

    // Automatic source may burst but never block; external source may
    // block but never burst. Anything else falls back to cycle-steal.
    always_comb begin
        if (!src_ext) begin
            eff_mode = (mode_sel == MODE_BURST) ? BM_BURST : BM_STEAL;
        end else begin
            eff_mode = (mode_sel == MODE_BLOCK) ? BM_BLOCK : BM_STEAL;
        end
    end

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic src_ext,
    input  logic sense_edge,
    input  logic accept,
    input  logic req_n,
    output logic req_hit
);

    typedef struct packed {
        logic req_n_prev;
        logic pend;
    } det_t;

    det_t det_d, det_q;
    logic fall;

    assign fall = det_q.req_n_prev & ~req_n;

    always_comb begin
        det_d            = det_q;
        det_d.req_n_prev = req_n;
        // A falling edge is kept until a request is accepted; it is only
        // remembered while the channel is armed for external edge sensing.
        det_d.pend       = armed & src_ext & sense_edge & ~accept
                         & (det_q.pend | fall);
        if (!src_ext) begin
            req_hit = 1'b1;
        end else if (sense_edge) begin
            req_hit = det_q.pend | fall;
        end else begin
            req_hit = ~req_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '{req_n_prev: 1'b1, pend: 1'b0};
        end else begin
            det_q <= det_d;
        end
    end

    // R7: a remembered edge never survives a disarmed cycle
    p_pend_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !det_q.pend);

endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int BLK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             abort,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             src_ext,
    input  logic [1:0]       mode_sel,
    input  logic             sense_edge,
    input  logic             ack_en,
    input  logic [BLK_W-1:0] blk_size,
    input  logic             req_n,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             xfer_stb,
    output logic             ack,
    output logic             active,
    output logic             done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [BLK_W-1:0] BLK_ONE = BLK_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] rem;
        logic [BLK_W-1:0] blk;
        logic             first;
        logic             done;
    } seq_t;

    seq_t      seq_d, seq_q;
    eff_mode_e eff_mode;
    logic      req_hit;
    logic      accept;

    dma_mode_decode u_mode (
        .src_ext  (src_ext),
        .mode_sel (mode_sel),
        .eff_mode (eff_mode)
    );

    dma_req_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (active),
        .src_ext    (src_ext),
        .sense_edge (sense_edge),
        .accept     (accept),
        .req_n      (req_n),
        .req_hit    (req_hit)
    );

    assign active   = (seq_q.phase != PH_IDLE);
    assign bus_req  = (seq_q.phase == PH_HOLD);
    assign xfer_stb = bus_req & bus_gnt;
    assign ack      = xfer_stb & seq_q.first & src_ext & ack_en;
    assign done     = seq_q.done;
    assign accept   = (seq_q.phase == PH_WAIT) & req_hit & ~abort;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (abort) begin
            seq_d.phase = PH_IDLE;
            seq_d.first = 1'b0;
        end else begin
            unique case (seq_q.phase)
                PH_IDLE: begin
                    if (arm) begin
                        if (xfer_count == '0) begin
                            seq_d.done = 1'b1;
                        end else begin
                            seq_d.phase = PH_WAIT;
                            seq_d.rem   = xfer_count;
                        end
                    end
                end
                PH_WAIT: begin
                    if (accept) begin
                        seq_d.phase = PH_HOLD;
                        seq_d.first = 1'b1;
                        seq_d.blk   = (blk_size == '0) ? BLK_ONE : blk_size;
                    end
                end
                PH_HOLD: begin
                    if (xfer_stb) begin
                        seq_d.rem   = seq_q.rem - CNT_ONE;
                        seq_d.blk   = seq_q.blk - BLK_ONE;
                        seq_d.first = 1'b0;
                        if (seq_q.rem == CNT_ONE) begin
                            seq_d.phase = PH_IDLE;
                            seq_d.done  = 1'b1;
                        end else begin
                            unique case (eff_mode)
                                BM_BURST: seq_d.phase = PH_HOLD;
                                BM_BLOCK: seq_d.phase =
                                    (seq_q.blk == BLK_ONE) ? PH_WAIT : PH_HOLD;
                                default:  seq_d.phase = PH_WAIT;
                            endcase
                        end
                    end
                end
                default: seq_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, rem: '0, blk: '0, first: 1'b0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // R2: an armed automatic channel requests the bus on the following cycle
    p_auto_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bus_req && !src_ext && !abort) |=> bus_req);

    // R3: the done pulse only appears with the channel disabled
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!active && !bus_req));

    // R4: cycle-steal releases the bus after every unit
    p_steal_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && eff_mode == BM_STEAL) |=> !bus_req);

    // R5: a held bus is not dropped without a transfer or an abort
    p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !xfer_stb && !abort) |=> bus_req);

    // R9: acknowledge never lasts two cycles in a row
    p_ack_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R10: abort disables the channel without completion
    p_abort_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!active && !bus_req && !done));

    // R11: a zero count completes at once without enabling
    p_zero_arm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !active && !abort && xfer_count == '0) |=> (done && !active));

endmodule

// File: tb/dma_req_seq_bench.sv
module dma_req_seq_bench;

    localparam int CNT_W = 8;
    localparam int BLK_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic             abort = 1'b0;
    logic [CNT_W-1:0] xfer_count = '0;
    logic             src_ext = 1'b0;
    logic [1:0]       mode_sel = 2'd0;
    logic             sense_edge = 1'b0;
    logic             ack_en = 1'b0;
    logic [BLK_W-1:0] blk_size = '0;
    logic             req_n = 1'b1;
    logic             bus_gnt = 1'b1;
    logic             bus_req, xfer_stb, ack, active, done;

    dma_req_seq #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_dma_req_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm), .abort(abort),
        .xfer_count(xfer_count), .src_ext(src_ext), .mode_sel(mode_sel),
        .sense_edge(sense_edge), .ack_en(ack_en), .blk_size(blk_size),
        .req_n(req_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
        .xfer_stb(xfer_stb), .ack(ack), .active(active), .done(done)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    int    stb_cnt = 0, ack_cnt = 0, done_cnt = 0;
    int    cycles = 0;
    int    gnt_mode = 0;
    logic [7:0] lfsr = 8'h5a;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // grant pattern: steady or pseudo-random stutter
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bus_gnt = (gnt_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
    end

    // behavioural reference model: 0 off, 1 waiting, 2 holding bus
    int m_state = 0, m_rem = 0, m_blk = 0, m_first = 0, m_done = 0;
    int m_pend = 0, m_prev = 1;

    function automatic int model_mode();
        if (!src_ext) return (mode_sel == 2'd1) ? 1 : 0;
        return (mode_sel == 2'd2) ? 2 : 0;
    endfunction

    always @(posedge clk) begin : model
        int hit, fall, acc, stb, ns, nrem, nblk, nfirst, ndone, npend;
        if (!rst_n) begin
            m_state = 0; m_rem = 0; m_blk = 0; m_first = 0;
            m_done = 0; m_pend = 0; m_prev = 1;
        end else begin
            fall = (m_prev == 1 && req_n == 1'b0) ? 1 : 0;
            if (!src_ext) hit = 1;
            else if (sense_edge) hit = (m_pend != 0 || fall != 0) ? 1 : 0;
            else hit = (req_n == 1'b0) ? 1 : 0;
            acc = (m_state == 1 && hit != 0 && !abort) ? 1 : 0;
            stb = (m_state == 2 && bus_gnt) ? 1 : 0;
            ns = m_state; nrem = m_rem; nblk = m_blk; nfirst = m_first; ndone = 0;
            npend = (m_state != 0 && src_ext && sense_edge && acc == 0 &&
                     (m_pend != 0 || fall != 0)) ? 1 : 0;
            if (abort) begin
                ns = 0; nfirst = 0;
            end else if (m_state == 0) begin
                if (arm) begin
                    if (xfer_count == 0) ndone = 1;
                    else begin ns = 1; nrem = int'(xfer_count); end
                end
            end else if (m_state == 1) begin
                if (acc != 0) begin
                    ns = 2; nfirst = 1;
                    nblk = (blk_size == 0) ? 1 : int'(blk_size);
                end
            end else if (stb != 0) begin
                nrem = m_rem - 1; nblk = m_blk - 1; nfirst = 0;
                if (nrem == 0) begin ns = 0; ndone = 1; end
                else if (model_mode() == 0) ns = 1;
                else if (model_mode() == 2 && nblk == 0) ns = 1;
            end
            m_state = ns; m_rem = nrem; m_blk = nblk; m_first = nfirst;
            m_done = ndone; m_pend = npend; m_prev = int'(req_n);
        end
    end

    // compare every output against the model away from the clock edge
    always @(negedge clk) begin
        int e_req, e_stb, e_ack;
        if (rst_n) begin
            e_req = (m_state == 2) ? 1 : 0;
            e_stb = (e_req != 0 && bus_gnt) ? 1 : 0;
            e_ack = (e_stb != 0 && m_first != 0 && src_ext && ack_en) ? 1 : 0;
            check(cur_req, "bus_req", int'(bus_req), e_req);
            check(cur_req, "xfer_stb", int'(xfer_stb), e_stb);
            check(cur_req, "ack", int'(ack), e_ack);
            check(cur_req, "active", int'(active), (m_state != 0) ? 1 : 0);
            check(cur_req, "done", int'(done), m_done);
            if (xfer_stb) stb_cnt++;
            if (ack) ack_cnt++;
            if (done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=0", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_counts();
        stb_cnt = 0; ack_cnt = 0; done_cnt = 0;
    endtask

    task automatic arm_go(int cnt);
        xfer_count = CNT_W'(cnt);
        arm = 1'b1;
        tick();
        arm = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && (active || arm); i++) tick();
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", "bus_req after reset", int'(bus_req), 0);
        check("R1", "active after reset", int'(active), 0);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "ack after reset", int'(ack), 0);
        tick();

        // R2 R5 R3: automatic burst with stuttering grant
        cur_req = "R5"; gnt_mode = 1; src_ext = 0; mode_sel = 2'd1; ack_en = 1;
        clear_counts();
        arm_go(5);
        @(negedge clk);
        check("R2", "active after arm", int'(active), 1);
        tick();
        @(negedge clk);
        check("R2", "bus_req two cycles after arm", int'(bus_req), 1);
        wait_idle();
        check("R3", "burst strobe total", stb_cnt, 5);
        check("R3", "burst done pulses", done_cnt, 1);
        check("R9", "no ack on automatic source", ack_cnt, 0);

        // R4: cycle-steal, legal and illegal combinations
        cur_req = "R4"; gnt_mode = 0;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            mode_sel = 2'(m);
            clear_counts();
            arm_go(3);
            wait_idle();
            check("R4", "steal strobe total", stb_cnt, 3);
        end

        // R6: external level sensing with per-transfer ack
        cur_req = "R6"; src_ext = 1; sense_edge = 0; mode_sel = 2'd0; ack_en = 1;
        req_n = 1; clear_counts();
        arm_go(4);
        tick(6);
        check("R6", "no strobe with request high", stb_cnt, 0);
        req_n = 0;
        wait_idle();
        req_n = 1;
        check("R6", "level strobe total", stb_cnt, 4);
        check("R9", "ack per steal transfer", ack_cnt, 4);

        cur_req = "R4"; mode_sel = 2'd1; gnt_mode = 1; clear_counts();
        arm_go(2);
        req_n = 0;
        wait_idle();
        req_n = 1;
        check("R4", "external burst demoted strobes", stb_cnt, 2);

        // R7: falling edge sensing
        cur_req = "R7"; sense_edge = 1; mode_sel = 2'd0; gnt_mode = 0; clear_counts();
        arm_go(3);
        tick(2);
        req_n = 0;
        tick(10);
        check("R7", "held low gives one transfer", stb_cnt, 1);
        for (int i = 0; i < 3; i++) begin
            req_n = 1; tick();
            req_n = 0; tick();
        end
        req_n = 1;
        wait_idle();
        check("R7", "edge strobe total", stb_cnt, 3);

        // R8: block mode, one ack per block
        cur_req = "R8"; mode_sel = 2'd2; blk_size = 4'd3; gnt_mode = 1; clear_counts();
        arm_go(7);
        for (int i = 0; i < 4; i++) begin
            req_n = 0; tick();
            req_n = 1; tick(5);
        end
        wait_idle();
        check("R8", "block strobe total", stb_cnt, 7);
        check("R9", "one ack per block", ack_cnt, 3);

        blk_size = '0; ack_en = 0; clear_counts();
        arm_go(2);
        for (int i = 0; i < 3; i++) begin
            req_n = 0; tick();
            req_n = 1; tick(4);
        end
        wait_idle();
        check("R8", "zero block size acts as one", stb_cnt, 2);
        check("R9", "no ack when disabled", ack_cnt, 0);

        // R10: abort in mid-burst
        cur_req = "R10"; src_ext = 0; mode_sel = 2'd1; gnt_mode = 0; clear_counts();
        arm_go(20);
        tick(4);
        abort = 1; tick(); abort = 0;
        @(negedge clk);
        check("R10", "active after abort", int'(active), 0);
        check("R10", "bus_req after abort", int'(bus_req), 0);
        tick(3);
        check("R10", "no done after abort", done_cnt, 0);

        // R11: re-arm while busy and zero count
        cur_req = "R11"; mode_sel = 2'd0; clear_counts();
        arm_go(6);
        tick(2);
        arm_go(2);
        wait_idle();
        check("R11", "re-arm while active ignored", stb_cnt, 6);
        clear_counts();
        arm_go(0);
        @(negedge clk);
        check("R11", "zero count done pulse", int'(done), 1);
        check("R11", "zero count stays disabled", int'(active), 0);
        tick(3);
        check("R11", "zero count no strobe", stb_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule